// File: doc/BRIEF.md
# Gated Retriggerable Pulse Generator

This block is a clocked, counter-based monostable. It drives a pulse that lasts a programmable number of clock cycles, and it also provides the complement of that pulse. Three level inputs can start the pulse:

- an active-low trigger line that fires on its falling edge;
- an active-high trigger line that fires on its rising edge;
- an active-low clear that fires when it is released.

Each of these edges counts only when the other two lines are at their enabling levels.

The clear has a second role. While it is held low, any running pulse stops and no new pulse can start. Any qualifying edge that arrives while a pulse is running loads the full length again. A trigger train whose period is shorter than the programmed length therefore keeps the output high for as long as it lasts. Inputs are assumed to be already synchronous to the clock.

Top module: `retrig_oneshot`

## Requirements
- R1: While `clear_n` is 0, `pulse` is 0, whatever `fall_in` and `rise_in` do. Taking `clear_n` low during a pulse ends that pulse in the same cycle.
- R2: A falling edge on `fall_in` (1 on the previous clock, 0 on the current one) starts a pulse when `rise_in` is 1 and `clear_n` is 1 on that clock.
- R3: A rising edge on `rise_in` (0 then 1) starts a pulse when `fall_in` is 0 and `clear_n` is 1 on that clock.
- R4: A rising edge on `clear_n` (0 then 1) starts a pulse when `fall_in` is 0 and `rise_in` is 1 on that clock.
- R5: If `fall_in` stays 1, or `rise_in` stays 0, then edges on the other trigger line start no pulse.
- R6: A qualifying edge during a running pulse loads the full length again, so the pulse is extended.
- R7: A qualifying edge train whose period is shorter than `pulse_len` keeps `pulse` continuously 1.
- R8: `pulse_n` is always the inverse of `pulse`.
- R9: After the clock edge that samples the last qualifying edge, `pulse` is 1 for exactly `pulse_len` cycles. The output goes high one clock after the edge is presented.
- R10: If `clear_n` is 0 in the same cycle as an edge on `fall_in` or `rise_in`, the clear wins and no pulse starts.
- R11: A `pulse_len` of 0 produces no pulse. The value is sampled at the trigger.
- R12: While `rst` is 1 on a clock edge, the counter clears. After reset, the previous-value registers hold levels at which no edge is seen, so the first clock after reset starts no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fall_in | input | 1 | Trigger line that fires on its falling edge |
| rise_in | input | 1 | Trigger line that fires on its rising edge |
| clear_n | input | 1 | Active-low clear; its release is also a trigger |
| pulse_len | input | CW | Pulse length in clock cycles |
| pulse | output | 1 | Pulse output, active high |
| pulse_n | output | 1 | Complement of `pulse` |

## Verification
Edge detection and the counter load both happen at the clock edge that first sees a qualifying input change. The output therefore rises one clock after the new input levels are applied. After a trigger it stays high for `pulse_len` samples, while a falling clear drops it at once.

The driver applies each input pattern at the falling clock edge. For that same cycle it queues the output level that the requirements predict. The monitor compares both outputs just after the following rising edge, so every expected item lines up with the one register stage between input and output.

// File: rtl/retrig_pkg.sv
package retrig_pkg;

  // Per-line sampled levels, kept together so the history register and the
  // qualifier agree on bit positions.
  typedef struct packed {
    logic fall_in;
    logic rise_in;
    logic clr_n;
  } trig_lvl_t;

  localparam int NUM_LINES = $bits(trig_lvl_t);

  // Previous-value reset levels chosen so that no edge is seen right after reset.
  localparam trig_lvl_t IDLE_PREV = '{fall_in: 1'b0, rise_in: 1'b1, clr_n: 1'b1};

endpackage

// File: rtl/retrig_hist.sv
module retrig_hist #(
  parameter int              N    = 3,
  parameter logic [N-1:0]    IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cur,
  output logic [N-1:0] prev
);

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) prev[i] <= IDLE[i];
      else     prev[i] <= cur[i];
    end
  end

endmodule

// File: rtl/retrig_qualify.sv
module retrig_qualify
  import retrig_pkg::*;
(
  input  trig_lvl_t cur,
  input  trig_lvl_t prev,
  output logic      fire
);

  logic fall_edge, rise_edge, clr_edge;

  always_comb begin
    fall_edge = prev.fall_in & ~cur.fall_in & cur.rise_in & cur.clr_n;
    rise_edge = ~prev.rise_in & cur.rise_in & ~cur.fall_in & cur.clr_n;
    clr_edge  = ~prev.clr_n & cur.clr_n & ~cur.fall_in & cur.rise_in;
    fire      = fall_edge | rise_edge | clr_edge;
  end

endmodule

// File: rtl/retrig_timer.sv
module retrig_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_n,
  input  logic          fire,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count,
  output logic          active
);

  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk) begin
    if (rst)                 count <= '0;
    else if (!clear_n)       count <= '0;
    else if (fire)           count <= load_val;
    else if (count != '0)    count <= count - ONE;
  end

  assign active = (count != '0);

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
  import retrig_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fall_in,
  input  logic          rise_in,
  input  logic          clear_n,
  input  logic [CW-1:0] pulse_len,
  output logic          pulse,
  output logic          pulse_n
);

  trig_lvl_t       cur_lvl, prev_lvl;
  logic            fire;
  logic            active;
  logic [CW-1:0]   count;

  assign cur_lvl = '{fall_in: fall_in, rise_in: rise_in, clr_n: clear_n};

  retrig_hist #(
    .N    (NUM_LINES),
    .IDLE (IDLE_PREV)
  ) u_hist (
    .clk  (clk),
    .rst  (rst),
    .cur  (cur_lvl),
    .prev (prev_lvl)
  );

  retrig_qualify u_qual (
    .cur  (cur_lvl),
    .prev (prev_lvl),
    .fire (fire)
  );

  retrig_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clear_n  (clear_n),
    .fire     (fire),
    .load_val (pulse_len),
    .count    (count),
    .active   (active)
  );

  // A low clear forces the output off in the same cycle.
  assign pulse   = active & clear_n;
  assign pulse_n = ~pulse;

endmodule

// File: rtl/retrig_oneshot_chk.sv
module retrig_oneshot_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          fall_in,
  input logic          rise_in,
  input logic          clear_n,
  input logic [CW-1:0] pulse_len,
  input logic [CW-1:0] count,
  input logic          fire
);

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    !clear_n |=> count == '0);  // R1

  AST_FALL_LOADS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fall_in) && !fall_in && rise_in && clear_n)
      |=> count == $past(pulse_len));  // R2

  AST_RISE_LOADS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rise_in) && rise_in && !fall_in && clear_n)
      |=> count == $past(pulse_len));  // R3

  AST_CLEAR_RELEASE_LOADS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clear_n) && clear_n && !fall_in && rise_in)
      |=> count == $past(pulse_len));  // R4

  AST_INHIBIT_HIGH: assert property (@(posedge clk) disable iff (rst)
    fall_in |-> !fire);  // R5

  AST_INHIBIT_LOW: assert property (@(posedge clk) disable iff (rst)
    !rise_in |-> !fire);  // R5

  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (fire && count != '0) |=> count == $past(pulse_len));  // R6

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!fire && clear_n && count != '0) |=> count == $past(count) - CW'(1));  // R9

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    !clear_n |-> !fire);  // R10

  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
    (fire && pulse_len == '0) |=> count == '0);  // R11

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> count == '0);  // R12

endmodule

bind retrig_oneshot retrig_oneshot_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fall_in   (fall_in),
  .rise_in   (rise_in),
  .clear_n   (clear_n),
  .pulse_len (pulse_len),
  .count     (count),
  .fire      (fire)
);

// File: tb/tb_retrig_oneshot.sv
module tb_retrig_oneshot;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fall_in = 1'b1;
  logic          rise_in = 1'b0;
  logic          clear_n = 1'b1;
  logic [CW-1:0] pulse_len = CW'(4);
  logic          pulse, pulse_n;

  typedef struct {
    logic  exp;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #2 clk = ~clk;

  retrig_oneshot #(.CW(CW)) dut (
    .clk       (clk),
    .rst       (rst),
    .fall_in   (fall_in),
    .rise_in   (rise_in),
    .clear_n   (clear_n),
    .pulse_len (pulse_len),
    .pulse     (pulse),
    .pulse_n   (pulse_n)
  );

  // Driver: one cycle of stimulus plus the output level expected after the next rising edge.
  task automatic step(input logic r, input logic a, input logic b, input logic c,
                      input logic e, input string tag);
    exp_t it;
    @(negedge clk);
    rst = r; fall_in = a; rise_in = b; clear_n = c;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Monitor / scoreboard.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        checks++;
        if (pulse !== it.exp) begin
          errors++;
          $display("FAIL %s: pulse=%0b expected %0b at %0t", it.tag, pulse, it.exp, $time);
        end
        checks++;
        if (pulse_n !== ~it.exp) begin
          errors++;
          $display("FAIL R8 (%s): pulse_n=%0b expected %0b at %0t", it.tag, pulse_n, ~it.exp, $time);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    step(1, 1, 0, 1, 0, "R12");
    step(1, 1, 0, 1, 0, "R12");
    // R2 with R5 (rise_in edge while fall_in high)
    step(0, 1, 1, 1, 0, "R5");
    step(0, 0, 1, 1, 1, "R2");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 1, "R9");
    step(0, 0, 1, 1, 0, "R9");
    // R3
    step(0, 0, 0, 1, 0, "R3");
    step(0, 0, 1, 1, 1, "R3");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 1, "R9");
    step(0, 0, 1, 1, 0, "R9");
    // R5: fall_in held high, then rise_in held low
    step(0, 1, 1, 1, 0, "R5");
    step(0, 1, 0, 1, 0, "R5");
    step(0, 1, 1, 1, 0, "R5");
    step(0, 1, 0, 1, 0, "R5");
    step(0, 0, 0, 1, 0, "R5");
    step(0, 1, 0, 1, 0, "R5");
    step(0, 0, 0, 1, 0, "R5");
    // R1 hold, then R4 release trigger
    step(0, 0, 0, 0, 0, "R1");
    step(0, 0, 1, 0, 0, "R1");
    step(0, 0, 1, 1, 1, "R4");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 1, "R4");
    step(0, 0, 1, 1, 0, "R4");
    // R1: clear cuts a pulse; release with fall_in high starts nothing
    step(0, 1, 1, 1, 0, "R5");
    step(0, 0, 1, 1, 1, "R2");
    step(0, 0, 1, 1, 1, "R2");
    step(0, 0, 1, 0, 0, "R1");
    step(0, 0, 1, 0, 0, "R1");
    step(0, 1, 1, 0, 0, "R1");
    step(0, 1, 1, 1, 0, "R1");
    // R6: retrigger mid-pulse reloads the full length
    step(0, 0, 1, 1, 1, "R6");
    step(0, 0, 1, 1, 1, "R6");
    step(0, 1, 1, 1, 1, "R6");
    step(0, 0, 1, 1, 1, "R6");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 1, "R9");
    step(0, 0, 1, 1, 0, "R9");
    // R7: trigger period 2 < length 4
    step(0, 1, 1, 1, 0, "R7");
    for (int i = 0; i < 8; i++) begin
      step(0, 0, 1, 1, 1, "R7");
      step(0, 1, 1, 1, 1, "R7");
    end
    step(0, 1, 1, 1, 1, "R7");
    step(0, 1, 1, 1, 1, "R7");
    step(0, 1, 1, 1, 0, "R7");
    // R10: falling edge on fall_in while clear is low
    step(0, 0, 1, 0, 0, "R10");
    step(0, 0, 1, 0, 0, "R10");
    step(0, 1, 1, 0, 0, "R10");
    step(0, 1, 1, 1, 0, "R10");
    // R11: zero length, then length one
    pulse_len = '0;
    step(0, 0, 1, 1, 0, "R11");
    step(0, 0, 1, 1, 0, "R11");
    pulse_len = CW'(1);
    step(0, 1, 1, 1, 0, "R11");
    step(0, 0, 1, 1, 1, "R9");
    step(0, 0, 1, 1, 0, "R9");
    // R12: reset in the middle of a pulse, no spurious pulse afterwards
    pulse_len = CW'(4);
    step(0, 1, 1, 1, 0, "R12");
    step(0, 0, 1, 1, 1, "R12");
    step(1, 0, 1, 1, 0, "R12");
    step(0, 0, 1, 1, 0, "R12");
    step(0, 0, 1, 1, 0, "R12");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule